// File: doc/BRIEF.md
# Fast Link Pulse Burst Generator

This block produces the digital timing of fast link pulse bursts for 10/100 Ethernet auto-negotiation. It takes a 16-bit link code word and sends it as one burst of up to 33 pulse positions. The even positions, counted from zero, always carry a framing pulse. Each odd position between two framing pulses carries one bit of the code word. A 1 is sent as a pulse, and a 0 is sent by leaving that position empty. The burst sends the lowest code word bit first, so the selector field goes out before any other bit.

While the enable input is held high, the block starts a new burst at a fixed start-to-start interval. At the default clock of 125 MHz, positions are 62.5 µs apart and each pulse lasts about 100 ns. Bursts start every 16 ms. The code word is sampled only at the start of a burst. A burst-complete strobe marks the end of each burst. Dropping the enable silences the output at once. Analog pulse shaping and the line driver sit downstream of this block.

Top module: `flp_burst_gen`

## Requirements
- R1: While reset is asserted, and after it is released with enable low, both `flp_pulse` and `burst_done` are low.
- R2: A burst has 33 positions, each `SLOT_CYC` cycles long. A pulse, when present, is high for the first `PULSE_CYC` cycles of its position and low for the rest.
- R3: Positions 0, 2, 4 … 32 (17 framing positions, counted from zero) always carry a pulse.
- R4: Position 2k+1 carries bit k of the code word: a pulse for 1, no pulse for 0. Bit 0 is sent first, so bits 4..0 (the selector field) lead the data.
- R5: `burst_done` is high for exactly one cycle, in the cycle right after the last position of a burst ends. No pulse is present in that cycle.
- R6: While enable stays high, bursts start every `PERIOD_CYC` cycles, measured start to start. The output stays low between bursts.
- R7: The code word is captured when a burst starts. A change during a burst has no effect until the next burst starts.
- R8: When enable is sampled low, the output is low and `burst_done` is low from the next cycle on. No done strobe is given for an aborted burst.
- R9: When enable is sampled high while idle, position 0 of a new burst starts in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Enables repeated burst generation |
| code_word | input | 16 | Link code word to send |
| flp_pulse | output | 1 | Pulse output, one bit |
| burst_done | output | 1 | One-cycle strobe after each completed burst |

## Verification
The bench compares every output cycle of each burst with a model, checking framing pulses and data bits against their expected positions. It uses all-zero, all-one, single-bit-at-either-end and mixed words, which expose a reversed bit order, a data position shifted by one, or framing pulses that depend on the data. It changes the code word in the middle of a burst, which catches a design that reads the live input instead of a captured copy. It drops enable in the middle of a burst and then raises it again, which catches a design that finishes the aborted burst, strobes done, or resumes from a stale position instead of starting fresh. The second burst of each run is also checked, which catches an interval counted from the end of a burst instead of from its start.

// File: rtl/flp_pkg.sv
package flp_pkg;
  localparam int FLP_POSITIONS = 33;
  localparam int FLP_BITS      = 16;
  typedef logic [FLP_BITS-1:0] flp_word_t;
endpackage

// File: rtl/flp_interval.sv
// Free-running start-to-start interval counter; idles at zero while disabled.
module flp_interval #(
  parameter int PERIOD_CYC = 2000000,
  localparam int PW = $clog2(PERIOD_CYC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic at_zero
);
  logic [PW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!en)                              cnt_d = '0;
    else if (cnt_q == PW'(PERIOD_CYC - 1)) cnt_d = '0;
    else                                  cnt_d = cnt_q + PW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign at_zero = (cnt_q == '0);
endmodule

// File: rtl/flp_slot_seq.sv
// Walks the burst positions: cycle-in-slot counter, position counter, done strobe.
module flp_slot_seq #(
  parameter int SLOT_CYC = 7812,
  parameter int NPOS     = 33,
  localparam int CW = $clog2(SLOT_CYC + 1),
  localparam int PW = $clog2(NPOS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          start,
  output logic          active,
  output logic [CW-1:0] cyc,
  output logic [PW-1:0] pos,
  output logic          done
);
  logic          act_d, done_d;
  logic [CW-1:0] cyc_d;
  logic [PW-1:0] pos_d;

  always_comb begin
    act_d  = active;
    cyc_d  = cyc;
    pos_d  = pos;
    done_d = 1'b0;
    if (!en) begin
      act_d = 1'b0;
      cyc_d = '0;
      pos_d = '0;
    end else if (start) begin
      act_d = 1'b1;
      cyc_d = '0;
      pos_d = '0;
    end else if (active) begin
      if (cyc == CW'(SLOT_CYC - 1)) begin
        cyc_d = '0;
        if (pos == PW'(NPOS - 1)) begin
          act_d  = 1'b0;
          pos_d  = '0;
          done_d = 1'b1;
        end else begin
          pos_d = pos + PW'(1);
        end
      end else begin
        cyc_d = cyc + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      cyc    <= '0;
      pos    <= '0;
      done   <= 1'b0;
    end else begin
      active <= act_d;
      cyc    <= cyc_d;
      pos    <= pos_d;
      done   <= done_d;
    end
  end
endmodule

// File: rtl/flp_pulse_map.sv
// Builds the per-position presence pattern and gates it with the pulse window.
module flp_pulse_map #(
  parameter int NPOS      = 33,
  parameter int WBITS     = 16,
  parameter int PULSE_CYC = 12,
  parameter int CW        = 13,
  parameter int PW        = 6
) (
  input  logic             active,
  input  logic [CW-1:0]    cyc,
  input  logic [PW-1:0]    pos,
  input  logic [WBITS-1:0] word,
  output logic             pulse
);
  logic [NPOS-1:0] present;

  for (genvar i = 0; i < NPOS; i++) begin : g_pos
    if (i % 2 == 0) begin : g_clk
      assign present[i] = 1'b1;
    end else begin : g_dat
      assign present[i] = word[i / 2];
    end
  end

  assign pulse = active && (cyc < CW'(PULSE_CYC)) && present[pos];
endmodule

// File: rtl/flp_burst_gen.sv
module flp_burst_gen #(
  parameter int CLK_KHZ    = 125000,
  parameter int SLOT_CYC   = (CLK_KHZ * 125) / 2000,
  parameter int PULSE_CYC  = CLK_KHZ / 10000,
  parameter int PERIOD_CYC = CLK_KHZ * 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        en,
  input  logic [15:0] code_word,
  output logic        flp_pulse,
  output logic        burst_done
);
  import flp_pkg::*;

  localparam int CW = $clog2(SLOT_CYC + 1);
  localparam int PW = $clog2(FLP_POSITIONS + 1);

  logic          rst_meta_n, rst_sync_n;
  logic          per_zero, start, active;
  logic [CW-1:0] cyc;
  logic [PW-1:0] pos;
  flp_word_t     word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign start = en && per_zero && !active;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  word_q <= '0;
    else if (start)   word_q <= code_word;
  end

  flp_interval #(.PERIOD_CYC(PERIOD_CYC)) u_interval (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .at_zero(per_zero)
  );

  flp_slot_seq #(.SLOT_CYC(SLOT_CYC), .NPOS(FLP_POSITIONS)) u_seq (
    .clk(clk), .rst_n(rst_sync_n), .en(en), .start(start),
    .active(active), .cyc(cyc), .pos(pos), .done(burst_done)
  );

  flp_pulse_map #(
    .NPOS(FLP_POSITIONS), .WBITS(FLP_BITS), .PULSE_CYC(PULSE_CYC), .CW(CW), .PW(PW)
  ) u_map (
    .active(active), .cyc(cyc), .pos(pos), .word(word_q), .pulse(flp_pulse)
  );
endmodule

// File: rtl/flp_burst_chk.sv
module flp_burst_chk #(
  parameter int PULSE_CYC = 12
) (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic flp_pulse,
  input logic burst_done
);
  logic [15:0] hi_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         hi_run <= '0;
    else if (flp_pulse) hi_run <= (hi_run == 16'hFFFF) ? hi_run : hi_run + 16'd1;
    else                hi_run <= '0;
  end

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    flp_pulse |-> (hi_run < 16'(PULSE_CYC)));

  assert_done_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |=> !burst_done);

  assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    burst_done |-> !flp_pulse);

  assert_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!flp_pulse && !burst_done));

  assert_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |=> flp_pulse);
endmodule

bind flp_burst_gen flp_burst_chk #(.PULSE_CYC(PULSE_CYC)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .en(en),
  .flp_pulse(flp_pulse), .burst_done(burst_done)
);

// File: tb/tb_flp_burst_gen.sv
`timescale 1ns/1ps
module tb_flp_burst_gen;
  localparam int SLOT   = 8;
  localparam int PULSE  = 2;
  localparam int PERIOD = 300;
  localparam int NPOS   = 33;
  localparam int NVEC   = 6;
  localparam logic [15:0] VEC [NVEC] = '{16'h0000, 16'hFFFF, 16'hA5C3,
                                         16'h0001, 16'h8000, 16'h01E1};

  logic clk, rst_n, en;
  logic [15:0] code_word;
  logic flp_pulse, burst_done;
  int checks = 0, errors = 0;

  flp_burst_gen #(.SLOT_CYC(SLOT), .PULSE_CYC(PULSE), .PERIOD_CYC(PERIOD)) dut (
    .clk(clk), .rst_n(rst_n), .en(en), .code_word(code_word),
    .flp_pulse(flp_pulse), .burst_done(burst_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic exp_pulse(input logic [15:0] w, input int t);
    int p, c;
    p = t / SLOT;
    c = t % SLOT;
    if (p >= NPOS || c >= PULSE) return 1'b0;
    if (p % 2 == 0) return 1'b1;
    return w[p / 2];
  endfunction

  task automatic report(input bit ok, input string req, input string what,
                        input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Drives en high with w1 and samples ncyc cycles. At sample chg_at the word becomes w2.
  // Bursts start at t=0 and t=PERIOD (R6, R9). The first uses w1 and the second w2 (R7).
  task automatic burst_run(input logic [15:0] w1, input logic [15:0] w2,
                           input int chg_at, input int ncyc, input string req);
    int bad_p = 0, bad_d = 0, t_p = -1, t_d = -1;
    logic ap = 0, ep = 0, ad = 0, ed = 0;
    code_word = w1;
    en = 1'b1;
    for (int t = 0; t < ncyc; t++) begin
      logic e_p, e_d;
      int tt;
      logic [15:0] w;
      @(negedge clk);
      tt  = (t < PERIOD) ? t : t - PERIOD;
      w   = (t < PERIOD) ? w1 : w2;
      e_p = exp_pulse(w, tt);
      e_d = (tt == NPOS * SLOT);
      if (flp_pulse !== e_p) begin
        if (bad_p == 0) begin t_p = t; ap = flp_pulse; ep = e_p; end
        bad_p++;
      end
      if (burst_done !== e_d) begin
        if (bad_d == 0) begin t_d = t; ad = burst_done; ed = e_d; end
        bad_d++;
      end
      if (t == chg_at) code_word = w2;
    end
    report(bad_p == 0, req, $sformatf("pulse pattern word=%h first bad t=%0d", w1, t_p),
           int'(ap), int'(ep));
    report(bad_d == 0, "R5", $sformatf("done strobe word=%h first bad t=%0d", w1, t_d),
           int'(ad), int'(ed));
    en = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int bad;
    rst_n = 1'b0;
    en = 1'b0;
    code_word = '0;
    repeat (3) @(negedge clk);
    report(flp_pulse == 1'b0 && burst_done == 1'b0, "R1", "outputs in reset",
           int'({flp_pulse, burst_done}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    report(flp_pulse == 1'b0 && burst_done == 1'b0, "R1", "outputs idle after reset",
           int'({flp_pulse, burst_done}), 0);

    // Table walk: framing R3, data R4, width R2, repeat R6
    for (int i = 0; i < NVEC; i++)
      burst_run(VEC[i], VEC[i], -1, 2 * PERIOD - 20, "R2 R3 R4 R6");

    // R7: a change in the middle of a burst only applies to the next burst
    burst_run(16'h1234, 16'hEDCB, 40, 2 * PERIOD - 20, "R7");

    // R8: drop en in the middle of a burst, then expect silence
    code_word = 16'hFFFF;
    en = 1'b1;
    repeat (60) @(negedge clk);
    en = 1'b0;
    bad = 0;
    for (int t = 0; t < 400; t++) begin
      @(negedge clk);
      if (flp_pulse !== 1'b0 || burst_done !== 1'b0) bad++;
    end
    report(bad == 0, "R8", "activity after enable dropped", bad, 0);

    // R9: re-enable starts a fresh burst at position 0
    burst_run(16'h5A5A, 16'h5A5A, -1, PERIOD + 10, "R9");

    // R1: reset in the middle of a burst silences the output
    en = 1'b1;
    code_word = 16'hFFFF;
    repeat (30) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    report(flp_pulse == 1'b0 && burst_done == 1'b0, "R1", "outputs during reset mid-burst",
           int'({flp_pulse, burst_done}), 0);
    en = 1'b0;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule